// File: doc/BRIEF.md
# Flash Status-Bit Poll Controller

This block sits on the host side of a parallel flash bus. Software writes a program or erase command sequence to the flash by some other path. It then pulses `start` on this controller with a valid polling address, the kind of operation, and bit 7 of the datum that was programmed. The controller then runs the completion loop without further help. It issues status reads at that one address through a request/acknowledge handshake. It compares bit 7 of each returned word against the value the finished operation must show, and it watches bit 5, which the flash raises when its internal timer expires.

A set timeout bit is not taken as final, because bit 7 and bit 5 can change together. After bit 5 is seen high, one more read is made, and only its bit 7 decides the result. Bit 7 can settle before the upper data lines do. For that reason, a matching status read is always followed by one more read, and that read's full word is captured as the result data. A parameter sets a limit on the number of ordinary poll reads, so the controller cannot hang on a flash that never answers.

When the run ends, `done` pulses for one cycle. The `pass` or `fail` flag then stays high until the next accepted start.

Top module: `dq7_poll_ctrl`

## Requirements
- R1: After reset, `rd_req`, `done`, `pass` and `fail` are all low.
- R2: Every read the controller issues uses the address captured at the accepted `start`. `rd_addr` holds steady while a request waits for its acknowledge.
- R3: The expected value for bit 7 of a status word is `prog_dq7` when `is_erase` is 0, and 1 when `is_erase` is 1.
- R4: When bit 7 of a status read equals the expected value, exactly one further read is made. `result_data` then holds the full word returned by that read, and the run ends with `pass`.
- R5: When bit 7 of a status read differs from the expected value and bit 5 is 0, the controller issues another status read at the same address.
- R6: When bit 7 differs and bit 5 is 1, exactly one re-check read follows. If its bit 7 matches, the run goes on as in R4. If it does not, the run ends with `fail` and no further read.
- R7: `rd_req` stays high until `rd_ack` is seen, and the controller advances only on an acknowledge. A slow acknowledge changes nothing but timing.
- R8: `done` is high for exactly one cycle per run, with exactly one of `pass`/`fail` high. That flag stays high until the next accepted `start` clears both flags.
- R9: With `MAX_POLLS` nonzero, if MAX_POLLS status reads in a row show a bit 7 mismatch and bit 5 at 0, the run ends with `fail` and no further read is made. With `MAX_POLLS` at 0 there is no limit.
- R10: A `start` pulse while a run is in progress has no effect on the address, the read count or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a polling run (accepted only when idle) |
| start_addr | input | ADDR_W | Valid polling address |
| is_erase | input | 1 | 1 for erase, 0 for program |
| prog_dq7 | input | 1 | Bit 7 of the programmed datum |
| rd_req | output | 1 | Read request to the flash bus |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge, with `rd_data` valid |
| rd_data | input | DATA_W | Read data word |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Run finished successfully (held) |
| fail | output | 1 | Run finished with error (held) |
| result_data | output | DATA_W | Full word from the read after a match |

## Verification
The bench builds the controller with `MAX_POLLS` set to 6 and the default widths. The small limit puts the poll-count cutoff in easy reach. It allows a pass on the last allowed read, a fail right at the limit, and a timeout re-check started on the sixth read. The responder can delay its acknowledge, and it returns status words whose upper bits differ from the true data. This shows that the captured result comes from the extra read and not from the status read.

// File: rtl/dq7_poll_ctrl.sv
module dq7_poll_ctrl #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              is_erase,
  input  logic              prog_dq7,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [DATA_W-1:0] result_data
);

  localparam int CNT_W = (MAX_POLLS > 0) ? $clog2(MAX_POLLS + 1) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_POLLS);

  typedef enum logic [2:0] {
    IDLE, READ1, CHECK1, READ2, CHECK2, FINAL_READ, DONE
  } state_t;

  state_t            state;
  logic [ADDR_W-1:0] addr_q;
  logic              exp_q;
  logic              dq7_q, dq5_q;
  logic [CNT_W-1:0]  polls;
  logic              pass_q, fail_q;
  logic [DATA_W-1:0] data_q;

  wire match     = (dq7_q == exp_q);
  wire limit_hit = (MAX_POLLS != 0) && (polls == LIMIT);

  assign rd_req      = (state == READ1) || (state == READ2) || (state == FINAL_READ);
  assign rd_addr     = addr_q;
  assign done        = (state == DONE);
  assign pass        = pass_q;
  assign fail        = fail_q;
  assign result_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      addr_q <= '0;
      exp_q  <= 1'b0;
      dq7_q  <= 1'b0;
      dq5_q  <= 1'b0;
      polls  <= '0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      data_q <= '0;
    end else begin
      case (state)
        IDLE: if (start) begin
          addr_q <= start_addr;
          exp_q  <= is_erase | prog_dq7;
          polls  <= '0;
          pass_q <= 1'b0;
          fail_q <= 1'b0;
          state  <= READ1;
        end
        READ1: if (rd_ack) begin
          dq7_q <= rd_data[7];
          dq5_q <= rd_data[5];
          polls <= polls + 1'b1;
          state <= CHECK1;
        end
        CHECK1: begin
          if (match)          state <= FINAL_READ;
          else if (dq5_q)     state <= READ2;
          else if (limit_hit) begin
            fail_q <= 1'b1;
            state  <= DONE;
          end else            state <= READ1;
        end
        READ2: if (rd_ack) begin
          dq7_q <= rd_data[7];
          dq5_q <= rd_data[5];
          state <= CHECK2;
        end
        CHECK2: begin
          if (match) state <= FINAL_READ;
          else begin
            fail_q <= 1'b1;
            state  <= DONE;
          end
        end
        FINAL_READ: if (rd_ack) begin
          data_q <= rd_data;
          pass_q <= 1'b1;
          state  <= DONE;
        end
        DONE:    state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

endmodule

module dq7_poll_ctrl_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              done,
  input logic              pass,
  input logic              fail
);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));

  assert_verdict_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  assert_verdict_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (done || ($stable(pass) && $stable(fail))));

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req);

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> $stable(rd_addr));

  assert_no_req_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

endmodule

bind dq7_poll_ctrl dq7_poll_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_addr(rd_addr), .done(done), .pass(pass), .fail(fail)
);

// File: tb/tb_dq7_poll_ctrl.sv
`timescale 1ns/1ps
module tb_dq7_poll_ctrl;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int MAXP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, is_erase = 1'b0, prog_dq7 = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic rd_req, rd_ack = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic done, pass, fail;
  logic [DW-1:0] result_data;

  always #2.5 clk = ~clk;

  dq7_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .is_erase(is_erase), .prog_dq7(prog_dq7), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .done(done), .pass(pass), .fail(fail),
    .result_data(result_data)
  );

  int checks = 0, fails = 0;
  int reads, addr_err, done_cnt, wait_cnt;
  int sc_nb, sc_mode, sc_delay;
  logic sc_exp;
  logic [DW-1:0] sc_true;
  logic [AW-1:0] sc_addr;

  // scenario table: erase, data, busy reads, mode (0 match, 1 dq5 then match, 2 dq5 then mismatch)
  localparam int NV = 8;
  localparam bit        V_ER [NV] = '{0, 0, 1, 0, 1, 0, 0, 0};
  localparam logic [15:0] V_D [NV] = '{16'h1280, 16'h3455, 16'h0000, 16'h00F0,
                                       16'h0000, 16'h7F7F, 16'hBEEF, 16'h0001};
  localparam int        V_NB [NV] = '{0, 3, 2, 1, 0, 5, 6, 5};
  localparam int        V_MD [NV] = '{0, 0, 0, 1, 2, 0, 0, 2};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_at(input int i);
    logic [DW-1:0] w;
    w = 16'h4A12;
    if (i < sc_nb) begin
      w[7] = ~sc_exp; w[5] = 1'b0;
    end else if (sc_mode == 0) begin
      if (i == sc_nb) begin w[7] = sc_exp; w[5] = 1'b0; end
      else w = sc_true;
    end else if (sc_mode == 1) begin
      if (i == sc_nb) begin w[7] = ~sc_exp; w[5] = 1'b1; end
      else if (i == sc_nb + 1) begin w[7] = sc_exp; w[5] = 1'b1; end
      else w = sc_true;
    end else begin
      if (i <= sc_nb + 1) begin w[7] = ~sc_exp; w[5] = 1'b1; end
      else w = sc_true;
    end
    return w;
  endfunction

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      if (wait_cnt < sc_delay) wait_cnt++;
      else begin
        wait_cnt = 0;
        rd_ack = 1'b1;
        rd_data = word_at(reads);
        if (rd_addr != sc_addr) addr_err++;
        reads++;
      end
    end
  end

  task automatic run_case(input bit er, input logic [15:0] d, input int nb, input int md,
                          input int dly, input bit inject, input logic [AW-1:0] a);
    bit exp_pass;
    int exp_reads, n;
    sc_exp = er | d[7];                       // R3
    sc_true = er ? 16'hFFFF : d;
    sc_nb = nb; sc_mode = md; sc_delay = dly; sc_addr = a;
    if (nb >= MAXP) begin exp_pass = 0; exp_reads = MAXP; end
    else if (md == 0) begin exp_pass = 1; exp_reads = nb + 2; end
    else if (md == 1) begin exp_pass = 1; exp_reads = nb + 3; end
    else begin exp_pass = 0; exp_reads = nb + 2; end
    @(negedge clk);
    reads = 0; addr_err = 0; done_cnt = 0; wait_cnt = 0;
    start = 1'b1; start_addr = a; is_erase = er; prog_dq7 = d[7];
    @(negedge clk);
    start = 1'b0;
    check(!pass && !fail, "R8 flags cleared at start", {pass, fail}, 0);
    if (inject) begin
      repeat (2) @(negedge clk);
      start = 1'b1; start_addr = a ^ 22'h155; is_erase = ~er; prog_dq7 = ~d[7];
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check(done, "R7 run completes", done, 1);
    check(pass == exp_pass && fail == !exp_pass, "R4/R6/R9 verdict", {pass, fail},
          {exp_pass, !exp_pass});
    check(reads == exp_reads, "R5/R6/R9 read count", reads, exp_reads);
    if (exp_pass) check(result_data == sc_true, "R4 result word", result_data, sc_true);
    check(addr_err == 0, "R2/R10 poll address", addr_err, 0);
    repeat (3) @(negedge clk);
    check(done_cnt == 1 && !done, "R8 done pulse", done_cnt, 1);
    check(pass == exp_pass && fail == !exp_pass, "R8 verdict held", {pass, fail},
          {exp_pass, !exp_pass});
    check(reads == exp_reads, "R9 no reads after end", reads, exp_reads);
  endtask

  initial begin
    sc_delay = 0; sc_nb = 0; sc_mode = 0; sc_exp = 0; sc_true = '0; sc_addr = '0;
    reads = 0; addr_err = 0; done_cnt = 0; wait_cnt = 0;
    repeat (3) @(negedge clk);
    check(!rd_req && !done && !pass && !fail, "R1 reset outputs",
          {rd_req, done, pass, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd_req && !done && !pass && !fail, "R1 idle after reset",
          {rd_req, done, pass, fail}, 0);
    for (int i = 0; i < NV; i++)
      run_case(V_ER[i], V_D[i], V_NB[i], V_MD[i], 0, 0, 22'h012345 + 22'(i * 7));
    // R7: slow acknowledge
    run_case(0, 16'h00A7, 1, 0, 4, 0, 22'h2AAAA);
    // R7 + R6 with delayed acknowledge on the recheck path
    run_case(1, 16'h0000, 2, 1, 3, 0, 22'h00100);
    // R10: start pulse while busy is ignored
    run_case(0, 16'h5500, 3, 0, 0, 1, 22'h3F0F0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule